// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-stage register. On each rising clock edge it can keep its contents, move them one place in either direction, or take a new word from a set of eight shared parallel lines. The stages are named A through H; A sits at bit 0 and H at bit 7. The shared lines act as tri-state outputs in most modes. They become inputs when a parallel load is selected.

For synthesis, each shared line is split into three signals: a data-in bit, a data-out bit and a drive-enable bit. A pad wrapper can merge them onto real bidirectional pins. Two serial outputs always carry copies of the end stages A and H. These outputs never float, so the block can be chained with neighbours in either direction.

An active-low clear empties the register at once, without waiting for a clock edge. The clear takes priority over any mode. The two active-low output enables control only the shared-line drivers. Register operation carries on whatever the enables say.

Top module: `usr8_shifter`

## Requirements
- R1: With mode = 2'b00 (mode[1] high bit), a rising clock edge leaves all eight stages unchanged.
- R2: With mode = 2'b01, a rising edge shifts toward H: bit 0 (stage A) takes `sin_right`, and each bit i > 0 takes the old bit i-1.
- R3: With mode = 2'b10, a rising edge shifts toward A: bit 7 (stage H) takes `sin_left`, and each bit i < 7 takes the old bit i+1.
- R4: With mode = 2'b11, a rising edge copies `pdata_in` into the register, with bit i going to stage i.
- R5: While `clr_n` is low, every stage reads 0 without any clock edge, and the clock has no effect in any mode.
- R6: `pdata_oe` is all ones when `oe_a_n` and `oe_b_n` are both low and mode is not 2'b11. Otherwise it is all zeros. Its eight bits are always equal.
- R7: `pdata_out` always equals the register contents. `ser_a` equals bit 0 and `ser_h` equals bit 7.
- R8: The levels of `oe_a_n` and `oe_b_n` have no effect on holding, shifting, loading or clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all mode operations act on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 keep, 01 toward H, 10 toward A, 11 load |
| oe_a_n | input | 1 | First output enable for the shared lines, active low |
| oe_b_n | input | 1 | Second output enable for the shared lines, active low |
| sin_right | input | 1 | Serial bit that enters stage A when shifting toward H |
| sin_left | input | 1 | Serial bit that enters stage H when shifting toward A |
| pdata_in | input | 8 | Input side of the shared parallel lines |
| pdata_out | output | 8 | Output side of the shared parallel lines (current contents) |
| pdata_oe | output | 8 | Per-line drive enable, active high |
| ser_a | output | 1 | Always-driven copy of stage A |
| ser_h | output | 1 | Always-driven copy of stage H |

## Verification
The assertions check four things on every clock edge: the register update for each of the four modes, the zero contents whenever the clear is held, and the rule that the drivers switch off during a load and always switch as one group. The bench scenarios show what no single-edge property can. These are the clear taking effect between clock edges, the full truth table of the enables in every mode, register sequences that run on while the lines are floating, and the serial outputs tracking the end stages across many shift runs.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_next.sv
module usr_next
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  usr_mode_e        mode,
  input  logic             sin_right,
  input  logic             sin_left,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  // Neighbour sources for each stage, with the serial inputs at the open ends
  logic [WIDTH-1:0] from_low;
  logic [WIDTH-1:0] from_high;

  assign from_low  = {cur[WIDTH-2:0], sin_right};
  assign from_high = {sin_left, cur[WIDTH-1:1]};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        MODE_HOLD: nxt[i] = cur[i];
        MODE_SHR:  nxt[i] = from_low[i];
        MODE_SHL:  nxt[i] = from_high[i];
        default:   nxt[i] = din[i];
      endcase
    end
  end
endmodule

// File: rtl/usr_drive.sv
module usr_drive
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  usr_mode_e        mode,
  output logic [WIDTH-1:0] line_oe
);
  logic drive;

  // The drivers turn off during a load whatever the enables say
  assign drive = ~oe_a_n & ~oe_b_n & (mode != MODE_LOAD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_oe
    assign line_oe[i] = drive;
  end
endmodule

// File: rtl/usr8_shifter.sv
module usr8_shifter
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             sin_right,
  input  logic             sin_left,
  input  logic [WIDTH-1:0] pdata_in,
  output logic [WIDTH-1:0] pdata_out,
  output logic [WIDTH-1:0] pdata_oe,
  output logic             ser_a,
  output logic             ser_h
);
  localparam int TOP = WIDTH - 1;

  usr_mode_e        mode_e;
  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] stages_nxt;

  assign mode_e = usr_mode_e'(mode);

  usr_next #(.WIDTH(WIDTH)) u_next (
    .cur       (stages),
    .mode      (mode_e),
    .sin_right (sin_right),
    .sin_left  (sin_left),
    .din       (pdata_in),
    .nxt       (stages_nxt)
  );

  usr_drive #(.WIDTH(WIDTH)) u_drive (
    .oe_a_n  (oe_a_n),
    .oe_b_n  (oe_b_n),
    .mode    (mode_e),
    .line_oe (pdata_oe)
  );

  // Pure asynchronous clear; the enables never reach this register
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stages <= '0;
    else        stages <= stages_nxt;
  end

  assign pdata_out = stages;
  assign ser_a     = stages[0];
  assign ser_h     = stages[TOP];

  assert_hold_R1: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b00) |=> (stages == $past(stages)));

  assert_shr_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b01) |=> (stages == {$past(stages[TOP-1:0]), $past(sin_right)}));

  assert_shl_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b10) |=> (stages == {$past(sin_left), $past(stages[TOP:1])}));

  assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |=> (stages == $past(pdata_in)));

  assert_clear_R5: assert property (@(posedge clk)
    (!clr_n) |-> (stages == '0));

  assert_load_undriven_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |-> (pdata_oe == '0));

  assert_oe_uniform_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (pdata_oe != '0) |-> (pdata_oe == '1));
endmodule

// File: tb/sim_usr8_shifter.sv
module sim_usr8_shifter;
  logic       clk = 1'b0;
  logic       clr_n;
  logic [1:0] mode;
  logic       oe_a_n, oe_b_n, sin_right, sin_left;
  logic [7:0] pdata_in, pdata_out, pdata_oe;
  logic       ser_a, ser_h;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model;

  always #5 clk = ~clk;

  usr8_shifter #(.WIDTH(8)) u0 (
    .clk, .clr_n, .mode, .oe_a_n, .oe_b_n, .sin_right, .sin_left,
    .pdata_in, .pdata_out, .pdata_oe, .ser_a, .ser_h
  );

  // {mode[1:0], sin_right, sin_left, oe_a_n, oe_b_n, pdata_in[7:0]}
  localparam int NV = 20;
  localparam logic [13:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 8'h3C},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00},
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'h5A},
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81},
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 8'h7E},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00},
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3},
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01},
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  function automatic logic [7:0] ref_next(logic [7:0] q, logic [1:0] m,
                                          logic sr, logic sl, logic [7:0] d);
    case (m)
      2'b00:   return q;
      2'b01:   return {q[6:0], sr};
      2'b10:   return {sl, q[7:1]};
      default: return d;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check({tag, " R7 pdata_out"}, pdata_out, model);
    check({tag, " R7 ser_a"}, {7'd0, ser_a}, {7'd0, model[0]});
    check({tag, " R7 ser_h"}, {7'd0, ser_h}, {7'd0, model[7]});
  endtask

  task automatic apply(logic [13:0] v);
    {mode, sin_right, sin_left, oe_a_n, oe_b_n, pdata_in} = v;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    clr_n = 1'b0;
    apply({2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF});
    model = 8'h00;
    // R5: clear held across edges, even with load selected
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset state", pdata_out, 8'h00);
    // Clear is released on a falling edge (synchronised deassertion)
    clr_n = 1'b1;

    // Walk the table: drive at the falling edge, check drive enables, then results
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k]);
      #1;
      check($sformatf("R6 vec%0d oe", k), pdata_oe,
            (!oe_a_n && !oe_b_n && mode != 2'b11) ? 8'hFF : 8'h00);
      @(posedge clk);
      model = ref_next(model, mode, sin_right, sin_left, pdata_in);
      @(negedge clk);
      // R1 R2 R3 R4 R8: next state follows the mode, whatever the enables
      check($sformatf("R1-4/R8 vec%0d state", k), pdata_out, model);
      check_outs($sformatf("vec%0d", k));
    end

    // R6: every combination of enables in every mode
    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 4; e++) begin
        mode = m[1:0];
        {oe_a_n, oe_b_n} = e[1:0];
        #1;
        check($sformatf("R6 mode%0d en%0d", m, e), pdata_oe,
              (e == 0 && m != 3) ? 8'hFF : 8'h00);
      end
    end

    // R5: clear asserted between edges takes effect with no clock edge
    mode = 2'b11; pdata_in = 8'hE7; oe_a_n = 1'b0; oe_b_n = 1'b0;
    @(posedge clk); model = 8'hE7;
    @(negedge clk);
    check("R4 load before clear", pdata_out, 8'hE7);
    #2 clr_n = 1'b0;
    #1;
    model = 8'h00;
    check("R5 async clear mid-cycle", pdata_out, 8'h00);
    check_outs("R5 clear");
    // R5: clear beats a shift at the following edge
    mode = 2'b01; sin_right = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R5 clear priority over shift", pdata_out, 8'h00);
    clr_n = 1'b1;

    // R8: clear with the lines floating still works
    mode = 2'b11; pdata_in = 8'h99; oe_a_n = 1'b1; oe_b_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 load while floating", pdata_out, 8'h99);
    clr_n = 1'b0;
    #1;
    check("R8 clear while floating", pdata_out, 8'h00);
    @(negedge clk);
    clr_n = 1'b1;

    // R2: a long run of shifts toward H, with serial outputs tracked
    model = 8'h00;
    mode = 2'b01;
    for (int k = 0; k < 10; k++) begin
      sin_right = k[0];
      @(posedge clk);
      model = {model[6:0], sin_right};
      @(negedge clk);
      check_outs($sformatf("R2 run%0d", k));
    end
    // R3: a long run of shifts toward A
    mode = 2'b10;
    for (int k = 0; k < 10; k++) begin
      sin_left = ~k[1];
      @(posedge clk);
      model = {sin_left, model[7:1]};
      @(negedge clk);
      check_outs($sformatf("R3 run%0d", k));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule